// File: doc/BRIEF.md
# 3x3 Median Noise Filter

This block cleans impulse noise out of a raster-scan pixel stream. Every accepted pixel is taken as the bottom-right corner of a 3x3 neighbourhood: the pixel, the two before it on the same line, and the same three columns on the two previous lines. Once such a neighbourhood is complete, the block emits the median of its nine values. Isolated extreme values vanish, and steps in brightness keep their position.

Two line-length delay lines and three 3-deep shift rows present all nine pixels at once. A fixed network of 19 compare-and-swap nodes reduces them to the median. Each node is one comparator steering two 2:1 multiplexers, with the smaller value on its low port and the larger on its high port. The nodes sit in nine dependency stages with a register after each, so one median leaves per clock, nine cycles after its pixel entered.

A small fill controller tracks how many lines have started, using the line start marker. It has four states. In `ST_WAIT_SOL` it waits for the first line start. It moves to `ST_FILL_L0` on that line start, to `ST_FILL_L1` on the next one, and to `ST_STREAM` on the third. It stays in `ST_STREAM` until reset. Output is suppressed until the neighbourhood is complete.

Top module: `median3x3_filter`

## Requirements
- R1: While reset is low, and after it is released, `out_valid` stays low until the first complete neighbourhood has travelled through the pipeline. A reset in the middle of a stream drops all results still in flight and sends the controller back to waiting.
- R2: Pixels that arrive before the first line start after reset are discarded. They produce no output and have no effect on later results.
- R3: The controller moves one step, WAIT_SOL → FILL_L0 → FILL_L1 → STREAM, on each accepted pixel flagged as a line start. It changes state at no other time and stays in STREAM until reset. The first output therefore belongs to the third line.
- R4: Results exist only in STREAM, and only for the third and later pixels of a line (column index 2 and up, counting from 0 at the line start pixel). The first two pixels of every line produce no output.
- R5: `out_pix` equals the median (the 5th smallest) of the nine pixels in columns c-2..c of the current line and of the two lines before it. Every line is exactly LINE_LEN pixels long.
- R6: Each result appears with `out_valid` high exactly 9 clock cycles after the edge that accepted its pixel. Pixels on consecutive cycles give results on consecutive cycles.
- R7: Cycles with `in_valid` low leave the window and the line delays unchanged, so gaps in the stream do not change any result.
- R8: Repeated values are handled like any others. A node passes equal inputs through unswapped, a flat neighbourhood gives back its own value, and a single extreme pixel in a flat area is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel strobe |
| in_sol | input | 1 | Marks the first pixel of a line (qualified by in_valid) |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Median result strobe |
| out_pix | output | PIX_W | Median of the 3x3 neighbourhood |

## Verification
A line start can be accepted, resetting the column count and stepping the controller, in the same cycle that the sorting pipeline delivers the medians of the previous line's last pixels. The bench provokes this by sending whole lines back to back with no idle cycles, and also with random gaps. A behavioural model keeps its own copies of the lines, predicts for every clock whether a result is due and what its value is, and compares `out_valid` and `out_pix` on every cycle. A wrong value, a missing strobe or an extra strobe at a line boundary therefore shows up exactly where it happens.

// File: rtl/median3x3_pkg.sv
package median3x3_pkg;

    localparam int NET_NODES  = 19;
    localparam int NET_STAGES = 9;
    localparam int NET_LANES  = 9;
    localparam int MID_LANE   = 4;

    typedef enum logic [1:0] {
        ST_WAIT_SOL,
        ST_FILL_L0,
        ST_FILL_L1,
        ST_STREAM
    } fill_state_t;

    // Node descriptor: {stage, low lane, high lane}, one hex digit each.
    function automatic int node_desc(input int n);
        case (n)
            0:  return 'h012;
            1:  return 'h045;
            2:  return 'h078;
            3:  return 'h101;
            4:  return 'h134;
            5:  return 'h167;
            6:  return 'h212;
            7:  return 'h245;
            8:  return 'h278;
            9:  return 'h303;
            10: return 'h358;
            11: return 'h347;
            12: return 'h436;
            13: return 'h414;
            14: return 'h425;
            15: return 'h547;
            16: return 'h642;
            17: return 'h764;
            default: return 'h842;
        endcase
    endfunction

    function automatic int node_stage(input int n);
        return (node_desc(n) >> 8) & 'hf;
    endfunction

    function automatic int node_lo(input int n);
        return (node_desc(n) >> 4) & 'hf;
    endfunction

    function automatic int node_hi(input int n);
        return node_desc(n) & 'hf;
    endfunction

    // Which node in stage s touches lane k; -1 when the lane passes through.
    function automatic int lane_node(input int s, input int k);
        for (int n = 0; n < NET_NODES; n++) begin
            if (node_stage(n) == s && (node_lo(n) == k || node_hi(n) == k))
                return n;
        end
        return -1;
    endfunction

endpackage

// File: rtl/mf_line_delay.sv
module mf_line_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] taps [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            taps[0] <= d;
            for (int i = 1; i < DEPTH; i++)
                taps[i] <= taps[i-1];
        end
    end

    assign q = taps[DEPTH-1];
endmodule

// File: rtl/mf_window.sv
module mf_window
    import median3x3_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int LINE_LEN = 64
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic                                in_sol,
    input  logic [PIX_W-1:0]                    in_pix,
    output logic                                win_vld,
    output logic [NET_LANES-1:0][PIX_W-1:0]     win
);
    localparam int ROWS = 3;
    localparam int COLS = 3;

    fill_state_t      state_q, state_d;
    logic [1:0]       col_q;
    logic             accept, take_win;
    logic [PIX_W-1:0] near_out, far_out;
    logic [PIX_W-1:0] row_q [ROWS][COLS];

    assign accept   = in_valid && ((state_q != ST_WAIT_SOL) || in_sol);
    assign take_win = accept && !in_sol && (col_q == 2'd2) && (state_d == ST_STREAM);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SOL: if (accept && in_sol) state_d = ST_FILL_L0;
            ST_FILL_L0:  if (accept && in_sol) state_d = ST_FILL_L1;
            ST_FILL_L1:  if (accept && in_sol) state_d = ST_STREAM;
            ST_STREAM:   state_d = ST_STREAM;
        endcase
    end

    // State register and the column position within the line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_SOL;
            col_q   <= 2'd0;
        end else begin
            state_q <= state_d;
            if (accept)
                col_q <= in_sol ? 2'd1 : ((col_q == 2'd2) ? 2'd2 : col_q + 2'd1);
        end
    end

    mf_line_delay #(.W(PIX_W), .DEPTH(LINE_LEN)) u_near (
        .clk(clk), .en(accept), .d(in_pix),   .q(near_out)
    );
    mf_line_delay #(.W(PIX_W), .DEPTH(LINE_LEN)) u_far (
        .clk(clk), .en(accept), .d(near_out), .q(far_out)
    );

    // Outputs: window strobe and the three shift rows.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            win_vld <= 1'b0;
        else
            win_vld <= take_win;
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            for (int r = 0; r < ROWS; r++) begin
                row_q[r][0] <= row_q[r][1];
                row_q[r][1] <= row_q[r][2];
            end
            row_q[0][2] <= far_out;
            row_q[1][2] <= near_out;
            row_q[2][2] <= in_pix;
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign win[r*COLS + c] = row_q[r][c];
        end
    end

    AST_STATE_ON_SOL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(state_q) |-> $past(in_valid && in_sol)); // R3
    AST_STREAM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STREAM) |=> (state_q == ST_STREAM)); // R3
    AST_SOL_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol) |=> !win_vld); // R4
endmodule

// File: rtl/mf_cas_node.sv
module mf_cas_node #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] lo,
    output logic [W-1:0] hi
);
    logic swap;

    assign swap = a > b;
    assign lo   = swap ? b : a;
    assign hi   = swap ? a : b;
endmodule

// File: rtl/mf_sort_net.sv
module mf_sort_net
    import median3x3_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_vld,
    input  logic [NET_LANES-1:0][PIX_W-1:0] in_win,
    output logic                            out_vld,
    output logic [PIX_W-1:0]                out_med
);
    localparam int CNT_W = $clog2(NET_STAGES + 1);

    logic [PIX_W-1:0]      src   [NET_STAGES][NET_LANES];
    logic [PIX_W-1:0]      nxt   [NET_STAGES][NET_LANES];
    logic [PIX_W-1:0]      stg_q [NET_STAGES][NET_LANES];
    logic [PIX_W-1:0]      n_lo  [NET_NODES];
    logic [PIX_W-1:0]      n_hi  [NET_NODES];
    logic [NET_STAGES-1:0] vld_q;

    for (genvar s = 0; s < NET_STAGES; s++) begin : g_stage
        for (genvar k = 0; k < NET_LANES; k++) begin : g_lane
            localparam int ND = lane_node(s, k);
            if (s == 0) begin : g_first
                assign src[s][k] = in_win[k];
            end else begin : g_later
                assign src[s][k] = stg_q[s-1][k];
            end
            if (ND < 0) begin : g_pass
                assign nxt[s][k] = src[s][k];
            end else if (node_lo(ND) == k) begin : g_low
                assign nxt[s][k] = n_lo[ND];
            end else begin : g_high
                assign nxt[s][k] = n_hi[ND];
            end
            always_ff @(posedge clk) stg_q[s][k] <= nxt[s][k];
        end
    end

    for (genvar n = 0; n < NET_NODES; n++) begin : g_node
        localparam int S = node_stage(n);
        localparam int A = node_lo(n);
        localparam int B = node_hi(n);
        mf_cas_node #(.W(PIX_W)) u_node (
            .a(src[S][A]), .b(src[S][B]), .lo(n_lo[n]), .hi(n_hi[n])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            vld_q <= '0;
        else
            vld_q <= {vld_q[NET_STAGES-2:0], in_vld};
    end

    assign out_vld = vld_q[NET_STAGES-1];
    assign out_med = stg_q[NET_STAGES-1][MID_LANE];

    // Cycles since reset, saturating, so latency checks never reach before it.
    logic [CNT_W-1:0] up_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            up_cnt <= '0;
        else if (up_cnt != CNT_W'(NET_STAGES))
            up_cnt <= up_cnt + 1'b1;
    end

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == CNT_W'(NET_STAGES) && $past(in_vld, 9)) |-> out_vld); // R6
    AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == CNT_W'(NET_STAGES) && out_vld) |-> $past(in_vld, 9)); // R6
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt < CNT_W'(NET_STAGES)) |-> !out_vld); // R1
endmodule

// File: rtl/median3x3_filter.sv
module median3x3_filter
    import median3x3_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int LINE_LEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    logic                            win_vld;
    logic [NET_LANES-1:0][PIX_W-1:0] win;

    mf_window #(.PIX_W(PIX_W), .LINE_LEN(LINE_LEN)) u_window (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_pix(in_pix), .win_vld(win_vld), .win(win)
    );

    mf_sort_net #(.PIX_W(PIX_W)) u_net (
        .clk(clk), .rst_n(rst_n), .in_vld(win_vld), .in_win(win),
        .out_vld(out_valid), .out_med(out_pix)
    );
endmodule

// File: tb/median3x3_filter_test.sv
module median3x3_filter_test;
    localparam int PW  = 8;
    localparam int LL  = 8;
    localparam int LAT = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sol = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic          out_valid;
    logic [PW-1:0] out_pix;

    always #4 clk = ~clk;

    median3x3_filter #(.PIX_W(PW), .LINE_LEN(LL)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_pix(in_pix), .out_valid(out_valid), .out_pix(out_pix)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // Reference model state
    int lines_seen = 0;
    int col = 0;
    int p1 [LL];
    int p2 [LL];
    int cur [LL];
    int due_q [$];
    int val_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int median9(input int v [9]);
        int w [9];
        w = v;
        for (int i = 1; i < 9; i++) begin
            for (int j = i; j > 0 && w[j-1] > w[j]; j--) begin
                int t = w[j];
                w[j] = w[j-1];
                w[j-1] = t;
            end
        end
        return w[4];
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            lines_seen = 0;
            col = 0;
            due_q.delete();
            val_q.delete();
        end else if (in_valid && (lines_seen > 0 || in_sol)) begin
            if (in_sol) begin
                p2 = p1;
                p1 = cur;
                if (lines_seen < 3) lines_seen++;
                col = 0;
            end
            if (col < LL) begin
                cur[col] = int'(in_pix);
                if (lines_seen >= 3 && col >= 2) begin
                    int v [9];
                    for (int d = 0; d < 3; d++) begin
                        v[d]   = p2[col-2+d];
                        v[3+d] = p1[col-2+d];
                        v[6+d] = cur[col-2+d];
                    end
                    due_q.push_back(cyc + LAT);
                    val_q.push_back(median9(v));
                end
                col++;
            end
        end
    end

    // Compare with the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
            end else if (due_q.size() > 0 && due_q[0] == cyc) begin
                chk(out_valid == 1'b1, "R6", int'(out_valid), 1);
                chk(int'(out_pix) == val_q[0], {phase, "/R5"}, int'(out_pix), val_q[0]);
                void'(due_q.pop_front());
                void'(val_q.pop_front());
            end else begin
                chk(out_valid == 1'b0, {phase, "/R4"}, int'(out_valid), 0);
            end
        end
    end

    task automatic send_pix(input bit sol, input int pix, input bit gaps);
        @(negedge clk);
        #1;
        in_valid = 1'b1;
        in_sol   = sol;
        in_pix   = PW'(pix);
        if (gaps && ($urandom % 3 == 0)) begin
            @(negedge clk);
            #1;
            in_valid = 1'b0;
            in_sol   = 1'b0;
            in_pix   = PW'($urandom);
        end
    endtask

    // kind 0: random, 1: flat with impulses, 2: all equal
    task automatic send_line(input int kind, input bit gaps);
        for (int i = 0; i < LL; i++) begin
            int v;
            case (kind)
                0: v = $urandom % 256;
                1: v = (i == 3) ? 255 : ((i == 5) ? 0 : 77);
                default: v = 9;
            endcase
            send_pix(i == 0, v, gaps);
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        #1;
        in_valid = 1'b0;
        in_sol   = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(2);
        // R2: stray pixels before any line start
        phase = "R2";
        for (int i = 0; i < 10; i++) send_pix(1'b0, 200, 1'b0);
        // R3: two fill lines, no output expected
        phase = "R3";
        send_line(0, 1'b0);
        send_line(0, 1'b0);
        // R5: random lines back to back
        phase = "R5";
        for (int i = 0; i < 4; i++) send_line(0, 1'b0);
        // R7: random lines with idle gaps
        phase = "R7";
        for (int i = 0; i < 3; i++) send_line(0, 1'b1);
        // R8: ties, flat areas and isolated impulses
        phase = "R8";
        send_line(2, 1'b0);
        send_line(1, 1'b0);
        send_line(1, 1'b0);
        send_line(1, 1'b1);
        send_line(2, 1'b0);
        send_line(2, 1'b0);
        // R1: reset in mid stream, then refill
        phase = "R1";
        send_pix(1'b1, 5, 1'b0);
        send_pix(1'b0, 6, 1'b0);
        send_pix(1'b0, 7, 1'b0);
        @(negedge clk);
        #1;
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (12) @(negedge clk);
        #1 rst_n = 1'b1;
        phase = "R3";
        for (int i = 0; i < 4; i++) send_line(0, 1'b1);
        idle(20);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 20000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule